// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one binary timer channel of the classic PC interval-timer kind. It counts ticks of a counter-clock enable from a loaded 16-bit initial count. A loaded zero stands for 65536. It drives one output pin whose waveform depends on the selected operating mode. A live count value is always presented, so a bus interface elsewhere can read it. A gate input either suspends counting or retriggers it, depending on the mode.

The host register interface, multi-channel wrapping and BCD counting are outside the block. A controller asserts the load strobe for one clock with the count and the 3-bit mode. From that clock on, the channel keeps time in ticks. A tick is a clock cycle with the counter-clock enable high that is not blocked by the gate and does not coincide with a restart.

Top module: `pit_channel`

## Requirements
- R1: A load value of 0 sets a period of 65536 ticks. The readback shows 0x0000 straight after the load and 0xFFFF after one tick in mode 0. In mode 4 the pulse comes after exactly 65536 ticks.
- R2: In modes 0, 1, 4 and 5 the readback equals (initial count − ticks since restart) mod 65536, so it wraps past zero.
- R3: In mode 0 (mode_sel = 0) out_pin is low after a load and is high once the ticks since restart reach the count.
- R4: In mode 1 (mode_sel = 1) out_pin is low while the ticks since restart are below the count and high from then on.
- R5: In mode 2 (mode_sel = 2) out_pin is high only when the ticks since restart are a nonzero multiple of the count. The readback is count − (ticks mod count).
- R6: In mode 3 (mode_sel = 3) out_pin is high for the first (count+1)/2 ticks of every period and low for the rest. The readback is count − ((2·ticks) mod count).
- R7: In modes 4 and 5 (mode_sel = 4, 5) out_pin is high only while the ticks since restart equal the count, once per restart.
- R8: In modes 1, 2, 3 and 5 a rising edge of gate, seen between two clocks, restarts timing from the initial count. In these modes the gate level does not stop ticks.
- R9: In modes 0 and 4 a low gate stops ticks and holds the readback. Raising the gate resumes counting without a reload.
- R10: A load restarts timing at that clock with the new count and mode. A load takes priority over a gate edge and a tick in the same clock.
- R11: mode_sel values 6 and 7 behave exactly as modes 2 and 3.
- R12: After reset the channel is in mode 0 with a count of 65536, zero ticks, the gate seen as low, out_pin low and a readback of 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter-clock enable, one tick per high cycle |
| gate | input | 1 | Gate level |
| load | input | 1 | Load strobe for count and mode |
| load_val | input | 16 | Initial count, 0 means 65536 |
| mode_sel | input | 3 | Operating mode taken at load |
| out_pin | output | 1 | Channel output waveform |
| count_rd | output | 16 | Live readable count |

## Verification
Directed runs come first. They exercise the 65536 case of a zero load in full, the readback wrapping below zero in mode 1, and gate suspension against gate retrigger. A reload in the middle of a period and the two aliased mode codes are also covered. A seeded random phase then mixes random modes, short counts, sparse ticks and gate toggles with occasional reloads. This separates the one-shot, periodic and single-pulse waveforms, and it shows whether each mode obeys the correct gate rule. A bench model of elapsed ticks predicts both outputs on every cycle. The odd counts in the random phase expose errors in the half-period and doubled-step arithmetic of mode 3.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [2:0] {
        PM_TC_IRQ    = 3'd0,
        PM_ONESHOT   = 3'd1,
        PM_RATE      = 3'd2,
        PM_SQUARE    = 3'd3,
        PM_SW_STROBE = 3'd4,
        PM_HW_STROBE = 3'd5
    } pit_mode_e;

    // codes 6 and 7 fold onto the periodic modes
    function automatic pit_mode_e fold_mode(input logic [2:0] code);
        if (code[2] && code[1])
            return pit_mode_e'({1'b0, code[1:0]});
        return pit_mode_e'(code);
    endfunction

    function automatic logic gate_retriggers(input pit_mode_e m);
        return (m == PM_ONESHOT) || (m == PM_RATE) ||
               (m == PM_SQUARE)  || (m == PM_HW_STROBE);
    endfunction

    function automatic logic gate_enables(input pit_mode_e m);
        return (m == PM_TC_IRQ) || (m == PM_SW_STROBE);
    endfunction

endpackage

// File: rtl/pit_gate_ctl.sv
module pit_gate_ctl
    import pit_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      gate,
    input  logic      tick_en,
    input  logic      load,
    input  pit_mode_e mode_q,
    output logic      restart,
    output logic      advance
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate;
    end

    always_comb begin
        restart = load || (gate && !gate_q && gate_retriggers(mode_q));
        advance = tick_en && !restart && (gate || !gate_enables(mode_q));
    end
endmodule

// File: rtl/pit_phase.sv
module pit_phase
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [CNT_W-1:0]     load_val,
    input  logic [2:0]           mode_sel,
    input  logic                 restart,
    input  logic                 advance,
    output pit_mode_e            mode_q,
    output logic [CNT_W:0]       span,
    output logic [CNT_W:0]       elapsed,
    output logic [CNT_W:0]       phase,
    output logic [CNT_W:0]       dphase,
    output logic [CNT_W-1:0]     live
);
    localparam int SPAN_W = CNT_W + 1;
    localparam logic [SPAN_W-1:0] FULL_SPAN = SPAN_W'(1) << CNT_W;

    logic [SPAN_W:0]   dsum;
    logic [SPAN_W-1:0] dstep;
    logic [SPAN_W-1:0] pnext;

    // doubled phase: advance by two, reduced modulo the span
    always_comb begin
        dsum = {1'b0, dphase} + (SPAN_W+1)'(2);
        if (dsum >= {1'b0, span}) dsum = dsum - {1'b0, span};
        if (dsum >= {1'b0, span}) dsum = dsum - {1'b0, span};
        dstep = dsum[SPAN_W-1:0];
        pnext = (phase + SPAN_W'(1) == span) ? '0 : phase + SPAN_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= PM_TC_IRQ;
            span    <= FULL_SPAN;
            elapsed <= '0;
            phase   <= '0;
            dphase  <= '0;
            live    <= '0;
        end else begin
            if (load) begin
                mode_q <= fold_mode(mode_sel);
                span   <= (load_val == '0) ? FULL_SPAN : {1'b0, load_val};
            end
            if (restart) begin
                elapsed <= '0;
                phase   <= '0;
                dphase  <= '0;
                live    <= load ? load_val : span[CNT_W-1:0];
            end else if (advance) begin
                if (elapsed <= span) elapsed <= elapsed + SPAN_W'(1);
                phase  <= pnext;
                dphase <= dstep;
                live   <= live - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pit_wave.sv
module pit_wave
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  pit_mode_e        mode_q,
    input  logic [CNT_W:0]   span,
    input  logic [CNT_W:0]   elapsed,
    input  logic [CNT_W:0]   phase,
    input  logic [CNT_W:0]   dphase,
    input  logic [CNT_W-1:0] live,
    output logic             out_pin,
    output logic [CNT_W-1:0] count_rd
);
    localparam int SPAN_W = CNT_W + 1;

    logic [SPAN_W:0]   half_sum;
    logic [SPAN_W-1:0] half;

    always_comb begin
        half_sum = ({1'b0, span} + (SPAN_W+1)'(1)) >> 1;
        half     = half_sum[SPAN_W-1:0];
        case (mode_q)
            PM_TC_IRQ,
            PM_ONESHOT:   out_pin = (elapsed >= span);
            PM_RATE:      out_pin = (elapsed != '0) && (phase == '0);
            PM_SQUARE:    out_pin = (phase < half);
            default:      out_pin = (elapsed == span);
        endcase
        case (mode_q)
            PM_RATE:      count_rd = CNT_W'(span - phase);
            PM_SQUARE:    count_rd = CNT_W'(span - dphase);
            default:      count_rd = live;
        endcase
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             gate,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [2:0]       mode_sel,
    output logic             out_pin,
    output logic [CNT_W-1:0] count_rd
);
    pit_mode_e        mode_q;
    logic             restart;
    logic             advance;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   elapsed;
    logic [CNT_W:0]   phase;
    logic [CNT_W:0]   dphase;
    logic [CNT_W-1:0] live;

    pit_gate_ctl i_gate (
        .clk(clk), .rst(rst), .gate(gate), .tick_en(tick_en), .load(load),
        .mode_q(mode_q), .restart(restart), .advance(advance)
    );

    pit_phase #(.CNT_W(CNT_W)) i_phase (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .mode_sel(mode_sel), .restart(restart), .advance(advance),
        .mode_q(mode_q), .span(span), .elapsed(elapsed), .phase(phase),
        .dphase(dphase), .live(live)
    );

    pit_wave #(.CNT_W(CNT_W)) i_wave (
        .mode_q(mode_q), .span(span), .elapsed(elapsed), .phase(phase),
        .dphase(dphase), .live(live), .out_pin(out_pin), .count_rd(count_rd)
    );

    a_r3_low_after_load: assert property (@(posedge clk) disable iff (rst)
        (load && fold_mode(mode_sel) == PM_TC_IRQ) |=> !out_pin);

    a_r4_low_after_load: assert property (@(posedge clk) disable iff (rst)
        (load && fold_mode(mode_sel) == PM_ONESHOT) |=> !out_pin);

    a_r5_no_pulse_at_start: assert property (@(posedge clk) disable iff (rst)
        (load && fold_mode(mode_sel) == PM_RATE) |=> !out_pin);

    a_r6_high_at_start: assert property (@(posedge clk) disable iff (rst)
        (load && fold_mode(mode_sel) == PM_SQUARE) |=> out_pin);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == PM_SW_STROBE || mode_q == PM_HW_STROBE) && out_pin && advance)
        |=> !out_pin);

    a_r9_gate_holds: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == PM_TC_IRQ || mode_q == PM_SW_STROBE) && !gate && !load)
        |=> $stable(count_rd));

    a_r2_down_step: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_TC_IRQ && advance)
        |=> count_rd == CNT_W'($past(count_rd) - CNT_W'(1)));
endmodule

// File: tb/test_pit_channel.sv
module test_pit_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        gate = 1'b0;
    logic        load = 1'b0;
    logic [15:0] load_val = '0;
    logic [2:0]  mode_sel = '0;
    logic        out_pin;
    logic [15:0] count_rd;

    int n_vec = 0;
    int n_bad = 0;
    int m_span, m_mode, m_d;
    bit m_gprev;

    always #10 clk = ~clk;

    pit_channel i_pit_channel (
        .clk(clk), .rst(rst), .tick_en(tick_en), .gate(gate), .load(load),
        .load_val(load_val), .mode_sel(mode_sel), .out_pin(out_pin),
        .count_rd(count_rd)
    );

    function automatic int fold(input int code);
        return (code >= 6) ? code - 4 : code;
    endfunction

    function automatic bit exp_out(input int m, input int n, input int d);
        case (m)
            0, 1:    return d >= n;
            2:       return (d != 0) && (d % n == 0);
            3:       return (d % n) < ((n + 1) / 2);
            default: return d == n;
        endcase
    endfunction

    function automatic int exp_cnt(input int m, input int n, input int d);
        case (m)
            2:       return (n - (d % n)) & 16'hFFFF;
            3:       return (n - ((2 * d) % n)) & 16'hFFFF;
            default: return (n - d) & 16'hFFFF;
        endcase
    endfunction

    function automatic string mode_tag(input int m);
        case (m)
            0:       return "R3";
            1:       return "R4";
            2:       return "R5";
            3:       return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag);
        bit eo;
        int ec;
        eo = exp_out(m_mode, m_span, m_d);
        ec = exp_cnt(m_mode, m_span, m_d);
        n_vec += 2;
        if (out_pin !== eo) begin
            n_bad++;
            $display("FAIL %s out_pin actual=%0b expected=%0b (mode %0d span %0d d %0d)",
                     tag, out_pin, eo, m_mode, m_span, m_d);
        end
        if (count_rd !== ec[15:0]) begin
            n_bad++;
            $display("FAIL %s count_rd actual=%h expected=%h (mode %0d span %0d d %0d)",
                     tag, count_rd, ec[15:0], m_mode, m_span, m_d);
        end
    endtask

    // one clock: drive at negedge, update the model at the edge, compare mid-high
    task automatic step(input bit ld, input int v, input int m, input bit g,
                        input bit t, input string tag);
        load = ld; load_val = v[15:0]; mode_sel = m[2:0]; gate = g; tick_en = t;
        @(posedge clk);
        #1;
        if (ld) begin
            m_span = (v == 0) ? 65536 : v;
            m_mode = fold(m);
            m_d    = 0;
        end else if (g && !m_gprev && (m_mode inside {1, 2, 3, 5})) begin
            m_d = 0;
        end else if (t && (g || !(m_mode inside {0, 4}))) begin
            m_d++;
        end
        m_gprev = g;
        #4;
        check(tag);
        @(negedge clk);
    endtask

    task automatic run(input int cycles, input bit g, input string tag);
        for (int i = 0; i < cycles; i++) step(1'b0, 0, 0, g, 1'b1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_span = 65536; m_mode = 0; m_d = 0; m_gprev = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        check("R12");                       // reset state
        @(negedge clk);
        for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 1'b0, 1'b1, "R12");

        // R1: zero count is 65536 in mode 0 and mode 4
        step(1'b1, 0, 0, 1'b1, 1'b0, "R1");
        run(3, 1'b1, "R1");
        step(1'b1, 0, 4, 1'b1, 1'b0, "R1");
        run(65540, 1'b1, "R1");

        // R2: mode 1 readback wraps below zero
        step(1'b1, 3, 1, 1'b1, 1'b0, "R2");
        run(6, 1'b1, "R2");

        // R8: gate rising edge restarts mode 2, gate low does not stop it
        step(1'b1, 5, 2, 1'b1, 1'b0, "R8");
        run(3, 1'b1, "R8");
        run(2, 1'b0, "R8");
        run(8, 1'b1, "R8");

        // R9: gate low suspends mode 0 and mode 4 without reload
        step(1'b1, 10, 0, 1'b1, 1'b0, "R9");
        run(3, 1'b1, "R9");
        run(4, 1'b0, "R9");
        run(9, 1'b1, "R9");
        step(1'b1, 4, 4, 1'b0, 1'b0, "R9");
        run(6, 1'b0, "R9");
        run(7, 1'b1, "R9");

        // R10: reload in the middle of a square-wave period
        step(1'b1, 6, 3, 1'b1, 1'b0, "R10");
        run(4, 1'b1, "R10");
        step(1'b1, 9, 3, 1'b1, 1'b1, "R10");
        run(12, 1'b1, "R10");

        // R11: codes 6 and 7 alias the periodic modes
        step(1'b1, 4, 6, 1'b1, 1'b0, "R11");
        run(10, 1'b1, "R11");
        step(1'b1, 5, 7, 1'b1, 1'b0, "R11");
        run(12, 1'b1, "R11");

        // random mix
        for (int i = 0; i < 30000; i++) begin
            bit ld, g, t;
            int v, m;
            ld = ($urandom_range(0, 59) == 0);
            v  = $urandom_range(0, 40);
            m  = $urandom_range(0, 7);
            g  = ($urandom_range(0, 15) == 0) ? !gate : gate;
            t  = ($urandom_range(0, 9) < 7);
            step(ld, v, m, g, t, ld ? "R10" : mode_tag(m_mode));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule